// File: doc/BRIEF.md
# Microcode Subroutine Return Stack

This block keeps the return addresses of a microsequencer. When a microinstruction calls a subroutine, or when a page-fail trap forces a push, the location being executed is written onto a small LIFO. A return removes the top entry. The block drives a registered return-address output, which the sequencer routes into its next-address multiplexer whenever the executing microinstruction is a return.

The output is its own latch, separate from the stack storage. It changes only on clocks that push, pop or rewind. After a push it holds the value just pushed. After a pop it holds the entry now on top, so the following return finds its target already waiting. A separate stack-rewind strobe does not empty the stack. It drops the pointer back to one entry, so the first address pushed since reset becomes the live return target again. A synchronous active-high reset clears the pointer, the stored entries and the output latch.

Top module: `ucode_ret_stack`

## Requirements
- R1: After a clock with `rst` high, `ret_addr` is 0.
- R2: A clock with `call_en` high loads `cur_loc` into the stack and into `ret_addr`, which shows it after that edge.
- R3: A clock with `trap_push` high behaves exactly as a call: `cur_loc` is pushed and appears on `ret_addr`.
- R4: On a clock with none of `call_en`, `ret_en`, `trap_push` or `stk_rewind` active, `ret_addr` keeps its value even when `cur_loc` changes.
- R5: A clock with only `ret_en` high removes the top entry, and `ret_addr` then shows the entry pushed just before it.
- R6: Fifteen nested pushes are held, and the returns that follow present them again in reverse order.
- R7: `stk_rewind` leaves exactly one entry on the stack, the first one pushed since reset, and shows it on `ret_addr`. A later push goes on top of it, and the return that follows shows it again.
- R8: Priority is rewind, then push, then pop. `call_en` and `ret_en` high together act as a push. `stk_rewind` high together with a push acts as a rewind only.
- R9: Reset also clears the stored entries and the pointer. A rewind right after reset shows 0, even if entry 0 held another value before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_en | input | 1 | Subroutine call in the executing microinstruction |
| ret_en | input | 1 | Return in the executing microinstruction |
| trap_push | input | 1 | Page-fail trap push |
| stk_rewind | input | 1 | Rewind the stack to its first entry |
| cur_loc | input | LOC_W (12) | Location of the executing microinstruction |
| ret_addr | output | LOC_W (12) | Registered return address |

## Verification
The main push and pop function is tried with several patterns. A short interleaved call, trap and return sequence tells a real LIFO apart from a single register. A run of fifteen nested calls unwound fully tells correct pointer wrap and indexing apart from an off-by-one read. Idle clocks that change `cur_loc` and carry non-return codes show that the output latch does not follow its input. Rewinds with entries above the first one, rewinds issued together with a call, and a rewind right after reset tell rewinding apart from emptying the stack, from ignoring the strobe, and from keeping stale data across a reset.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam int LOC_W_DEF = 12;
    localparam int PTR_W_DEF = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_POP    = 2'd2,
        ST_REWIND = 2'd3
    } stk_op_e;

    // Rewind wins over push, push wins over pop.
    function automatic stk_op_e pick_op(input logic rewind,
                                        input logic push,
                                        input logic pop);
        stk_op_e op;
        if (rewind)    op = ST_REWIND;
        else if (push) op = ST_PUSH;
        else if (pop)  op = ST_POP;
        else           op = ST_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] rd_idx
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        case (op)
            ST_PUSH:   ptr_d = ptr_q + ONE;
            ST_POP:    ptr_d = ptr_q - ONE;
            ST_REWIND: ptr_d = ONE;
            default:   ptr_d = ptr_q;
        endcase
    end

    // The entry that becomes the top after the operation.
    always_comb begin
        case (op)
            ST_POP:    rd_idx = ptr_q - TWO;
            ST_REWIND: rd_idx = '0;
            default:   rd_idx = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end
endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
    parameter int LOC_W = 12,
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [LOC_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [LOC_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [LOC_W-1:0] ent [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                ent[i] <= '0;
            else if (we && (wr_idx == PTR_W'(i)))
                ent[i] <= wr_data;
        end
    end

    assign rd_data = ent[rd_idx];
endmodule

// File: rtl/rstk_latch.sv
module rstk_latch
    import rstk_pkg::*;
#(
    parameter int LOC_W = LOC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [LOC_W-1:0] push_data,
    input  logic [LOC_W-1:0] top_data,
    output logic [LOC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                ST_PUSH:           q <= push_data;
                ST_POP, ST_REWIND: q <= top_data;
                default:           q <= q;
            endcase
        end
    end
endmodule

// File: rtl/ucode_ret_stack.sv
module ucode_ret_stack
    import rstk_pkg::*;
#(
    parameter int LOC_W = LOC_W_DEF,
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_en,
    input  logic             ret_en,
    input  logic             trap_push,
    input  logic             stk_rewind,
    input  logic [LOC_W-1:0] cur_loc,
    output logic [LOC_W-1:0] ret_addr
);
    stk_op_e          op;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] rd_idx;
    logic [LOC_W-1:0] top_data;

    assign op = pick_op(stk_rewind, call_en | trap_push, ret_en);

    rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ptr_q  (ptr_q),
        .rd_idx (rd_idx)
    );

    rstk_mem #(.LOC_W(LOC_W), .PTR_W(PTR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (op == ST_PUSH),
        .wr_idx  (ptr_q),
        .wr_data (cur_loc),
        .rd_idx  (rd_idx),
        .rd_data (top_data)
    );

    rstk_latch #(.LOC_W(LOC_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .push_data (cur_loc),
        .top_data  (top_data),
        .q         (ret_addr)
    );
endmodule

// File: rtl/ucode_ret_stack_chk.sv
module ucode_ret_stack_chk #(
    parameter int LOC_W = 12,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             call_en,
    input logic             ret_en,
    input logic             trap_push,
    input logic             stk_rewind,
    input logic [LOC_W-1:0] cur_loc,
    input logic [LOC_W-1:0] ret_addr,
    input logic [PTR_W-1:0] ptr
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ret_addr == '0) && (ptr == '0)); // R1

    AST_CALL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (call_en && !stk_rewind) |=> ret_addr == $past(cur_loc)); // R2

    AST_TRAP_LOADS: assert property (@(posedge clk) disable iff (rst)
        (trap_push && !stk_rewind) |=> ret_addr == $past(cur_loc)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(call_en || ret_en || trap_push || stk_rewind) |=> $stable(ret_addr)); // R4

    AST_POP_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (ret_en && !call_en && !trap_push && !stk_rewind)
        |=> ptr == PTR_W'($past(ptr) - PTR_W'(1))); // R5

    AST_PUSH_STEPS_UP: assert property (@(posedge clk) disable iff (rst)
        ((call_en || trap_push) && !stk_rewind)
        |=> ptr == PTR_W'($past(ptr) + PTR_W'(1))); // R6

    AST_REWIND_ONE: assert property (@(posedge clk) disable iff (rst)
        stk_rewind |=> ptr == PTR_W'(1)); // R7
endmodule

bind ucode_ret_stack ucode_ret_stack_chk #(.LOC_W(LOC_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .call_en    (call_en),
    .ret_en     (ret_en),
    .trap_push  (trap_push),
    .stk_rewind (stk_rewind),
    .cur_loc    (cur_loc),
    .ret_addr   (ret_addr),
    .ptr        (ptr_q)
);

// File: tb/ucode_ret_stack_bench.sv
`timescale 1ns/100ps
module ucode_ret_stack_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_en = 1'b0;
    logic        ret_en = 1'b0;
    logic        trap_push = 1'b0;
    logic        stk_rewind = 1'b0;
    logic [11:0] cur_loc = '0;
    logic [11:0] ret_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ucode_ret_stack u_ucode_ret_stack (
        .clk(clk), .rst(rst), .call_en(call_en), .ret_en(ret_en),
        .trap_push(trap_push), .stk_rewind(stk_rewind),
        .cur_loc(cur_loc), .ret_addr(ret_addr)
    );

    // {call, ret, trap, rewind, cur_loc, expected ret_addr}
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {4'b1000, 12'h002, 12'h002},  // R2
        {4'b1000, 12'h004, 12'h004},  // R2
        {4'b0000, 12'h777, 12'h004},  // R4
        {4'b0010, 12'hABC, 12'hABC},  // R3
        {4'b0100, 12'h000, 12'h004},  // R5
        {4'b0100, 12'h000, 12'h002},  // R5
        {4'b1000, 12'h010, 12'h010},  // R2
        {4'b1000, 12'h020, 12'h020},  // R2
        {4'b0001, 12'h000, 12'h002},  // R7
        {4'b1000, 12'h0FF, 12'h0FF},  // R7
        {4'b0100, 12'h000, 12'h002},  // R7
        {4'b1100, 12'h123, 12'h123},  // R8
        {4'b1001, 12'h555, 12'h002},  // R8
        {4'b0000, 12'hFFF, 12'h002}   // R4
    };
    localparam int VTAG [NV] = '{2, 2, 4, 3, 5, 5, 2, 2, 7, 7, 7, 8, 8, 4};

    task automatic check(input logic [11:0] exp, input int tag);
        n_chk++;
        if (ret_addr !== exp) begin
            n_bad++;
            $display("FAIL R%0d: ret_addr actual=%h expected=%h", tag, ret_addr, exp);
        end
    endtask

    task automatic step(input logic [3:0] ctl, input logic [11:0] loc,
                        input logic [11:0] exp, input int tag);
        @(negedge clk);
        {call_en, ret_en, trap_push, stk_rewind} = ctl;
        cur_loc = loc;
        @(posedge clk);
        #1;
        {call_en, ret_en, trap_push, stk_rewind} = 4'b0000;
        check(exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(12'h000, 1); // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(VEC[i][27:24], VEC[i][23:12], VEC[i][11:0], VTAG[i]);

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(12'h000, 1); // R1
        @(negedge clk);
        rst = 1'b0;

        // R6: fifteen nested calls, then unwind
        for (int k = 0; k < 15; k++)
            step(4'b1000, 12'(12'h100 + 2 * k), 12'(12'h100 + 2 * k), 6); // R6
        for (int k = 1; k < 15; k++)
            step(4'b0100, 12'h000, 12'(12'h100 + 2 * (14 - k)), 6);       // R6

        // R9: reset wipes entry 0 (held 0x100)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(4'b0001, 12'h3C3, 12'h000, 9); // R9

        // R4: non-return idle after two calls keeps the later one
        step(4'b1000, 12'h000, 12'h000, 2);
        step(4'b1000, 12'h001, 12'h001, 2);
        step(4'b0000, 12'h0A5, 12'h001, 4); // R4

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule